// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item Transfer Engine

This block moves bytes between a configuration item store and system memory. Software describes each transfer in a 16-byte descriptor held in memory and hands the engine the descriptor's 64-bit address through a small register window. The engine reads the descriptor through a byte-wide memory master. It can switch to a different item. It then copies item bytes out to memory, steps over them, or fills the item from memory. When it finishes, it writes a status word over the descriptor's control field.

The current item and the byte offset within it belong to the item selector, which sits outside this block. The engine asks the selector to change item, reads the byte at the current offset, advances the offset one byte at a time and, for writable items, stores a byte at the offset. Reads of the register window return a fixed 8-byte ASCII signature, which software uses to find the engine.

Top module: `cfg_dma_engine`

## Requirements
- R1: The address register accepts three write shapes: a 4-byte write at offset 0 sets the high half and clears the low half; a 4-byte write at offset 4 merges the low half and starts a transfer; an 8-byte write at offset 0 loads the whole address and starts a transfer. Every other write shape (for example 4 bytes at offset 2, 2 bytes at offset 0, 8 bytes at offset 4, 1 byte at offset 4) has no effect.
- R2: A read of size 1, 2, 4 or 8 bytes at byte offset a returns signature bytes a to a+size-1, with the lowest-offset byte in the most significant position. The signature is the ASCII string "CFG XFER", and byte 0 is 'C'.
- R3: A descriptor is 16 bytes, all big-endian: a 32-bit control word at +0, a 32-bit length at +4 and a 64-bit target address at +8. The engine fetches them in ascending address order.
- R4: Control bit 3 (select) makes the engine select the item whose key is in control bits 31:16 before it moves any data. Selecting rewinds the offset to 0.
- R5: The operation is chosen by priority: bit 1 (read) first, then bit 4 (write), then bit 2 (skip). When none of these bits is set, the length is treated as zero, no data moves and the status is success.
- R6: A read stores item bytes at consecutive target addresses, one byte per length unit, advancing the offset. When the item is invalid or the offset has reached the item length, the read stores zero bytes and the offset does not move.
- R7: A skip advances the offset by min(length, bytes left) and makes no memory writes for data.
- R8: A write copies length bytes from memory into the item only when the item is valid and writable and the length fits in the bytes left. Otherwise the status is an error and the item is unchanged. A write of length 0 succeeds.
- R9: On completion the engine writes 4 bytes at the descriptor address, big-endian: 0 for success or 1 (bit 0, error) for failure. If the descriptor fetch gets an error response, the engine skips the operation and writes status 1.
- R10: Starting a transfer clears the stored address, so a later low-half-only write starts a transfer whose high half is zero.
- R11: After reset the engine is idle. While a transfer is in progress (busy high), all address register writes are ignored.
- R12: An error response on a data access stops the transfer at once and the status is 1. Earlier bytes of that transfer stay in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_addr | input | 3 | Byte offset within the register window |
| reg_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature read data, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts and completes the request |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ready |
| mem_err | input | 1 | Error response, valid with mem_ready |
| item_sel | output | 1 | Select pulse: switch to item_key, rewind offset |
| item_key | output | 16 | Key of the item to select |
| item_ok | input | 1 | Current item exists |
| item_len | input | 32 | Length of the current item in bytes |
| item_off | input | 32 | Current offset within the item |
| item_wr_ok | input | 1 | Current item accepts writes |
| item_rbyte | input | 8 | Item byte at the current offset |
| item_step | output | 1 | Advance the offset by one |
| item_wen | output | 1 | Store item_wbyte at the current offset |
| item_wbyte | output | 8 | Byte to store into the item |

## Verification
The assertions assume that the item selector changes item_ok, item_len, item_off and item_wr_ok only in response to the engine's own select, step and store pulses. On that assumption, a write that passes the fit check stays in range for the rest of the transfer. They also assume that the memory side eventually raises mem_ready for a pending request. The bench's item model changes state only on those pulses, and its memory responder stalls on a repeating pattern that always completes. Error responses come only from fixed address bits, so the reference model can predict exactly which access fails.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

    // control word bit positions
    localparam int CTL_ERR  = 0;
    localparam int CTL_RD   = 1;
    localparam int CTL_SKIP = 2;
    localparam int CTL_SEL  = 3;
    localparam int CTL_WR   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_SEL,
        ST_WCHK,
        ST_RUN,
        ST_WB
    } seq_st_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RD,
        OP_WR,
        OP_SKIP
    } op_e;

endpackage

// File: rtl/cfg_dma_regs.sv
module cfg_dma_regs #(
    parameter int          AW  = 64,
    parameter logic [63:0] SIG = 64'h4346_4720_5846_4552
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [3:0]    reg_size,
    input  logic [AW-1:0] reg_wdata,
    output logic [63:0]   reg_rdata,
    input  logic          busy,
    output logic          start,
    output logic [AW-1:0] start_addr
);
    localparam int HALF = AW / 2;

    typedef struct packed {
        logic [AW-1:0] addr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        start      = 1'b0;
        start_addr = r_q.addr | {{HALF{1'b0}}, reg_wdata[HALF-1:0]};
        if (reg_wr && !busy) begin
            if (reg_size == 4'd4 && reg_addr == 3'd0) begin
                r_d.addr = {reg_wdata[HALF-1:0], {HALF{1'b0}}};
            end else if (reg_size == 4'd4 && reg_addr == 3'd4) begin
                start    = 1'b1;
                r_d.addr = '0;
            end else if (reg_size == 4'd8 && reg_addr == 3'd0) begin
                start      = 1'b1;
                start_addr = reg_wdata;
                r_d.addr   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // signature slice: lowest offset lands in the most significant byte
    logic [3:0]  end_b;
    logic [3:0]  tail_b;
    logic        legal;
    logic [63:0] msk;

    always_comb begin
        end_b  = {1'b0, reg_addr} + reg_size;
        tail_b = 4'd8 - end_b;
        legal  = (reg_size == 4'd1 || reg_size == 4'd2 ||
                  reg_size == 4'd4 || reg_size == 4'd8) && (end_b <= 4'd8);
        msk    = (reg_size == 4'd8) ? '1 : ((64'd1 << {reg_size, 3'b000}) - 64'd1);
        reg_rdata = legal ? ((SIG >> {tail_b, 3'b000}) & msk) : '0;
    end

endmodule

// File: rtl/cfg_dma_seq.sv
module cfg_dma_seq
    import cfg_dma_pkg::*;
#(
    parameter int AW    = 64,
    parameter int LW    = 32,
    parameter int KEY_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          busy,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ready,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_err,
    output logic          item_sel,
    output logic [KEY_W-1:0] item_key,
    input  logic          item_ok,
    input  logic [LW-1:0] item_len,
    input  logic [LW-1:0] item_off,
    input  logic          item_wr_ok,
    input  logic [7:0]    item_rbyte,
    output logic          item_step,
    output logic          item_wen,
    output logic [7:0]    item_wbyte
);
    localparam int DESC_W = 32 + LW + AW;
    localparam int DESC_B = DESC_W / 8;
    localparam int CNT_W  = $clog2(DESC_B);
    localparam logic [CNT_W-1:0] LAST_FETCH = CNT_W'(DESC_B - 1);
    localparam logic [CNT_W-1:0] LAST_WB    = CNT_W'(3);

    typedef struct packed {
        seq_st_e           st;
        op_e               op;
        logic [CNT_W-1:0]  cnt;
        logic [AW-1:0]     dptr;
        logic [DESC_W-1:0] desc;
        logic [LW-1:0]     len;
        logic [AW-1:0]     tgt;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    logic          in_rng;
    logic [LW-1:0] left;
    op_e           dec_op;

    assign busy     = (s_q.st != ST_IDLE);
    assign item_key = s_q.desc[DESC_W-1 -: KEY_W];

    always_comb begin
        s_d        = s_q;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = s_q.dptr + AW'(s_q.cnt);
        mem_wdata  = 8'h00;
        item_sel   = 1'b0;
        item_step  = 1'b0;
        item_wen   = 1'b0;
        item_wbyte = mem_rdata;
        in_rng     = item_ok && (item_off < item_len);
        left       = item_len - item_off;

        if (s_q.desc[DESC_W-32+CTL_RD])        dec_op = OP_RD;
        else if (s_q.desc[DESC_W-32+CTL_WR])   dec_op = OP_WR;
        else if (s_q.desc[DESC_W-32+CTL_SKIP]) dec_op = OP_SKIP;
        else                                   dec_op = OP_NONE;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_FETCH;
                    s_d.dptr = start_addr;
                    s_d.cnt  = '0;
                    s_d.err  = 1'b0;
                end
            end
            ST_FETCH: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    if (mem_err) begin
                        s_d.err = 1'b1;
                        s_d.st  = ST_WB;
                        s_d.cnt = '0;
                    end else begin
                        s_d.desc = {s_q.desc[DESC_W-9:0], mem_rdata};
                        if (s_q.cnt == LAST_FETCH) begin
                            s_d.st  = ST_DECODE;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
            end
            ST_DECODE: begin
                s_d.op  = dec_op;
                s_d.len = (dec_op == OP_NONE) ? '0 : s_q.desc[AW+LW-1 -: LW];
                s_d.tgt = s_q.desc[AW-1:0];
                s_d.err = 1'b0;
                if (s_q.desc[DESC_W-32+CTL_SEL]) s_d.st = ST_SEL;
                else if (dec_op == OP_WR)        s_d.st = ST_WCHK;
                else                             s_d.st = ST_RUN;
            end
            ST_SEL: begin
                item_sel = 1'b1;
                s_d.st   = (s_q.op == OP_WR) ? ST_WCHK : ST_RUN;
            end
            ST_WCHK: begin
                if (s_q.len == '0) begin
                    s_d.st = ST_WB;
                end else if (!in_rng || !item_wr_ok || (s_q.len > left)) begin
                    s_d.err = 1'b1;
                    s_d.st  = ST_WB;
                end else begin
                    s_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (s_q.len == '0) begin
                    s_d.st = ST_WB;
                end else begin
                    unique case (s_q.op)
                        OP_RD: begin
                            mem_valid = 1'b1;
                            mem_write = 1'b1;
                            mem_addr  = s_q.tgt;
                            mem_wdata = in_rng ? item_rbyte : 8'h00;
                            if (mem_ready) begin
                                if (mem_err) begin
                                    s_d.err = 1'b1;
                                    s_d.st  = ST_WB;
                                end else begin
                                    item_step = in_rng;
                                    s_d.tgt   = s_q.tgt + 1'b1;
                                    s_d.len   = s_q.len - 1'b1;
                                end
                            end
                        end
                        OP_WR: begin
                            mem_valid = 1'b1;
                            mem_addr  = s_q.tgt;
                            if (mem_ready) begin
                                if (mem_err) begin
                                    s_d.err = 1'b1;
                                    s_d.st  = ST_WB;
                                end else begin
                                    item_wen  = 1'b1;
                                    item_step = 1'b1;
                                    s_d.tgt   = s_q.tgt + 1'b1;
                                    s_d.len   = s_q.len - 1'b1;
                                end
                            end
                        end
                        OP_SKIP: begin
                            if (in_rng) begin
                                item_step = 1'b1;
                                s_d.tgt   = s_q.tgt + 1'b1;
                                s_d.len   = s_q.len - 1'b1;
                            end else begin
                                s_d.len = '0;
                            end
                        end
                        default: s_d.len = '0;
                    endcase
                end
            end
            ST_WB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = (s_q.cnt == LAST_WB) ? {7'b0, s_q.err} : 8'h00;
                if (mem_ready) begin
                    if (s_q.cnt == LAST_WB) begin
                        s_d.st  = ST_IDLE;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R11
    busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

    // R11
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    // R7
    step_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        item_step |-> (item_ok && (item_off < item_len)));

    // R8
    store_needs_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        item_wen |-> (item_wr_ok && item_step));

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
    parameter int          AW    = 64,
    parameter int          LW    = 32,
    parameter int          KEY_W = 16,
    parameter logic [63:0] SIG   = 64'h4346_4720_5846_4552
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [3:0]    reg_size,
    input  logic [AW-1:0] reg_wdata,
    output logic [63:0]   reg_rdata,
    output logic          busy,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ready,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_err,
    output logic          item_sel,
    output logic [KEY_W-1:0] item_key,
    input  logic          item_ok,
    input  logic [LW-1:0] item_len,
    input  logic [LW-1:0] item_off,
    input  logic          item_wr_ok,
    input  logic [7:0]    item_rbyte,
    output logic          item_step,
    output logic          item_wen,
    output logic [7:0]    item_wbyte
);
    logic          start;
    logic [AW-1:0] start_addr;

    cfg_dma_regs #(.AW(AW), .SIG(SIG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_size   (reg_size),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .start      (start),
        .start_addr (start_addr)
    );

    cfg_dma_seq #(.AW(AW), .LW(LW), .KEY_W(KEY_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .busy       (busy),
        .mem_valid  (mem_valid),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .mem_err    (mem_err),
        .item_sel   (item_sel),
        .item_key   (item_key),
        .item_ok    (item_ok),
        .item_len   (item_len),
        .item_off   (item_off),
        .item_wr_ok (item_wr_ok),
        .item_rbyte (item_rbyte),
        .item_step  (item_step),
        .item_wen   (item_wen),
        .item_wbyte (item_wbyte)
    );

endmodule

// File: tb/cfg_dma_engine_bench.sv
module cfg_dma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [3:0]  reg_size = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        busy;
    logic        mem_valid, mem_write;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ready = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        item_sel;
    logic [15:0] item_key;
    logic        item_ok;
    logic [31:0] item_len, item_off;
    logic        item_wr_ok;
    logic [7:0]  item_rbyte;
    logic        item_step, item_wen;
    logic [7:0]  item_wbyte;

    always #10 clk = ~clk;

    cfg_dma_engine u_cfg_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .item_sel(item_sel),
        .item_key(item_key), .item_ok(item_ok), .item_len(item_len),
        .item_off(item_off), .item_wr_ok(item_wr_ok), .item_rbyte(item_rbyte),
        .item_step(item_step), .item_wen(item_wen), .item_wbyte(item_wbyte)
    );

    int n_chk = 0;
    int n_bad = 0;

    // system memory model: bit 40 fails reads, bit 41 fails writes
    bit [7:0] mem [logic [63:0]];
    int stall = 0;

    // item store model
    logic [7:0]  idat [4][16];
    logic [7:0]  rdat [4][16];
    logic [31:0] ilen_m [4];
    bit          iwr_m [4];
    logic [15:0] cur_key = '0;
    logic [31:0] cur_off = '0;
    logic [15:0] ref_key = '0;
    logic [31:0] ref_off = '0;

    assign item_ok    = (cur_key < 16'd4);
    assign item_len   = item_ok ? ilen_m[cur_key[1:0]] : 32'd0;
    assign item_off   = cur_off;
    assign item_wr_ok = item_ok && iwr_m[cur_key[1:0]];
    assign item_rbyte = (item_ok && cur_off < 32'd16) ? idat[cur_key[1:0]][cur_off[3:0]] : 8'h00;

    // scoreboard queues
    logic [63:0] q_a [$];
    logic [7:0]  q_d [$];
    string       q_t [$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        stall = stall + 1;
        mem_ready = mem_valid && (stall % 3 != 0);
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
        mem_err   = mem_valid && (mem_write ? mem_addr[41] : mem_addr[40]);
    end

    // monitor and environment updates
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready && mem_write && !mem_err) begin
            mem[mem_addr] = mem_wdata;
            n_chk++;
            if (q_a.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected write: actual %h@%h expected none", mem_wdata, mem_addr);
            end else begin
                logic [63:0] ea;
                logic [7:0]  ed;
                string       et;
                ea = q_a.pop_front();
                ed = q_d.pop_front();
                et = q_t.pop_front();
                if (ea !== mem_addr || ed !== mem_wdata) begin
                    n_bad++;
                    $display("FAIL %s: actual %h@%h expected %h@%h", et, mem_wdata, mem_addr, ed, ea);
                end
            end
        end
        if (item_sel) begin
            cur_key <= item_key;
            cur_off <= '0;
        end else if (item_step) begin
            if (item_wen) idat[cur_key[1:0]][cur_off[3:0]] <= item_wbyte;
            cur_off <= cur_off + 1;
        end
    end

    task automatic push(input logic [63:0] a, input logic [7:0] d, input string t);
        q_a.push_back(a);
        q_d.push_back(d);
        q_t.push_back(t);
    endtask

    task automatic put_desc(input logic [63:0] dp, input logic [31:0] ctl,
                            input logic [31:0] len, input logic [63:0] tgt);
        for (int i = 0; i < 4; i++) mem[dp + 64'(i)] = ctl[31-8*i -: 8];
        for (int i = 0; i < 4; i++) mem[dp + 64'(4+i)] = len[31-8*i -: 8];
        for (int i = 0; i < 8; i++) mem[dp + 64'(8+i)] = tgt[63-8*i -: 8];
    endtask

    // reference behaviour built from the requirements
    task automatic model(input logic [63:0] dp, input logic [31:0] ctl,
                         input logic [31:0] len, input logic [63:0] tgt, input string tag);
        bit          err;
        bit          vld;
        logic [31:0] il;
        logic [1:0]  k;
        err = 0;
        if (dp[40]) begin
            err = 1;
        end else begin
            if (ctl[3]) begin ref_key = ctl[31:16]; ref_off = 0; end
            vld = (ref_key < 16'd4);
            k   = ref_key[1:0];
            il  = vld ? ilen_m[k] : 32'd0;
            if (ctl[1]) begin
                for (int i = 0; i < int'(len); i++) begin
                    logic [63:0] a;
                    a = tgt + 64'(i);
                    if (a[41]) begin err = 1; break; end
                    if (vld && ref_off < il) begin
                        push(a, rdat[k][ref_off[3:0]], tag);
                        ref_off++;
                    end else begin
                        push(a, 8'h00, tag);
                    end
                end
            end else if (ctl[4]) begin
                if (len != 0) begin
                    if (!vld || ref_off >= il || !iwr_m[k] || len > il - ref_off) err = 1;
                    else begin
                        for (int i = 0; i < int'(len); i++) begin
                            logic [63:0] a;
                            a = tgt + 64'(i);
                            if (a[40]) begin err = 1; break; end
                            rdat[k][ref_off[3:0]] = mem.exists(a) ? mem[a] : 8'h00;
                            ref_off++;
                        end
                    end
                end
            end else if (ctl[2]) begin
                while (len != 0 && vld && ref_off < il) begin ref_off++; len--; end
            end
        end
        for (int i = 0; i < 4; i++) push(dp + 64'(i), (i == 3) ? {7'b0, err} : 8'h00, tag);
    endtask

    task automatic reg_write(input logic [3:0] sz, input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_size = sz; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk({tag, " idle"}, 64'(busy), 64'd0);
        chk({tag, " drained"}, 64'(q_a.size()), 64'd0);
    endtask

    task automatic xfer(input logic [63:0] dp, input logic [31:0] ctl,
                        input logic [31:0] len, input logic [63:0] tgt, input string tag);
        put_desc(dp, ctl, len, tgt);
        model(dp, ctl, len, tgt, tag);
        reg_write(4'd8, 3'd0, dp);
        wait_idle(tag);
    endtask

    task automatic sig_chk(input logic [2:0] a, input logic [3:0] sz);
        string       s;
        logic [63:0] e;
        s = "CFG XFER";
        e = '0;
        for (int i = 0; i < int'(sz); i++) e = (e << 8) | 64'(s[int'(a) + i]);
        @(negedge clk);
        reg_addr = a; reg_size = sz;
        #1;
        chk("R2 signature", reg_rdata, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog: actual hung expected idle");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 16; j++) idat[k][j] = 8'h00;
        for (int j = 0; j < 4; j++) idat[0][j] = 8'hA0 + 8'(j);
        for (int j = 0; j < 6; j++) idat[1][j] = 8'h10 + 8'(j);
        for (int j = 0; j < 8; j++) idat[3][j] = 8'h30 + 8'(j);
        ilen_m[0] = 4; ilen_m[1] = 6; ilen_m[2] = 0; ilen_m[3] = 8;
        iwr_m[0] = 0;  iwr_m[1] = 1;  iwr_m[2] = 0;  iwr_m[3] = 0;
        rdat = idat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", 64'(busy), 64'd0);
        chk("R11 reset mem_valid", 64'(mem_valid), 64'd0);

        sig_chk(3'd0, 4'd8); sig_chk(3'd0, 4'd4); sig_chk(3'd4, 4'd4);
        sig_chk(3'd2, 4'd2); sig_chk(3'd7, 4'd1); sig_chk(3'd3, 4'd1);

        xfer(64'h100, {16'd0, 16'h000A}, 6, 64'h1000, "R3 R4 R6 R9 select read");
        xfer(64'h120, {16'd3, 16'h000C}, 3, 64'h1100, "R7 skip");
        xfer(64'h140, {16'd0, 16'h0002}, 2, 64'h1140, "R7 read after skip");
        xfer(64'h160, {16'd0, 16'h0016}, 2, 64'h1180, "R5 read wins");
        mem[64'h2000] = 8'h5A; mem[64'h2001] = 8'h5B;
        xfer(64'h180, {16'd1, 16'h001C}, 2, 64'h2000, "R5 R8 write wins");
        xfer(64'h1A0, {16'd1, 16'h000A}, 6, 64'h11C0, "R8 readback");
        xfer(64'h1C0, {16'd0, 16'h0008}, 5, 64'h1200, "R5 no op");
        xfer(64'h1E0, {16'd0, 16'h0002}, 1, 64'h1240, "R4 R5 offset rewound");
        xfer(64'h200, {16'd0, 16'h0018}, 1, 64'h2000, "R8 read-only");
        xfer(64'h220, {16'd1, 16'h0018}, 7, 64'h2000, "R8 too long");
        xfer(64'h240, {16'd1, 16'h000A}, 6, 64'h1280, "R8 unchanged");
        xfer(64'h260, {16'd9, 16'h000A}, 3, 64'h12C0, "R6 invalid item zeros");
        xfer(64'h280, {16'd9, 16'h0018}, 1, 64'h2000, "R8 invalid item write");
        xfer(64'h2A0, {16'd2, 16'h000A}, 2, 64'h1300, "R6 empty item zeros");
        xfer(64'h0000_0100_0000_0500, {16'd0, 16'h000A}, 2, 64'h1340, "R9 fetch error");
        xfer(64'h2C0, {16'd3, 16'h000A}, 4, 64'h0000_0200_0000_1000, "R12 write response error");
        xfer(64'h2E0, {16'd1, 16'h0018}, 2, 64'h0000_0100_0000_2000, "R12 read response error");

        // R1 R10: split trigger, then low half alone uses a zero high half
        put_desc(64'h0000_0001_0000_3000, {16'd3, 16'h000A}, 2, 64'h1400);
        put_desc(64'h3000, {16'd0, 16'h000A}, 1, 64'h1440);
        model(64'h0000_0001_0000_3000, {16'd3, 16'h000A}, 2, 64'h1400, "R1 split trigger");
        reg_write(4'd4, 3'd0, 64'h1);
        reg_write(4'd4, 3'd4, 64'h3000);
        wait_idle("R1 split trigger");
        model(64'h3000, {16'd0, 16'h000A}, 1, 64'h1440, "R10 address cleared");
        reg_write(4'd4, 3'd4, 64'h3000);
        wait_idle("R10 address cleared");

        // R1: ignored write shapes
        reg_write(4'd4, 3'd2, 64'h100);
        chk("R1 ignored 4@2", 64'(busy), 64'd0);
        reg_write(4'd2, 3'd0, 64'h100);
        chk("R1 ignored 2@0", 64'(busy), 64'd0);
        reg_write(4'd8, 3'd4, 64'h100);
        chk("R1 ignored 8@4", 64'(busy), 64'd0);
        reg_write(4'd1, 3'd4, 64'h100);
        chk("R1 ignored 1@4", 64'(busy), 64'd0);

        // R11: trigger while busy is dropped
        put_desc(64'h3100, {16'd0, 16'h000A}, 2, 64'h1480);
        put_desc(64'h3200, {16'd3, 16'h000A}, 2, 64'h14C0);
        model(64'h3100, {16'd0, 16'h000A}, 2, 64'h1480, "R11 busy ignores trigger");
        reg_write(4'd8, 3'd0, 64'h3100);
        reg_write(4'd8, 3'd0, 64'h3200);
        wait_idle("R11 busy ignores trigger");
        repeat (60) @(negedge clk);
        chk("R11 no late transfer", 64'(busy), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule